// File: doc/BRIEF.md
# DRAM Rank Refresh Sequencer

This block paces periodic refresh for a single DRAM rank. A free-running interval counter raises a refresh need after a programmable number of cycles. The sequencer then lets outstanding accesses drain and wakes the rank if it sits in a power-down state. It closes any open banks with a precharge-all, issues one refresh command and waits out the refresh recovery time. After that it either returns to normal service or parks the rank in self-refresh until an exit completes. While a sequence is under way, ordinary read and write bursts are held off through a single permission flag.

The surrounding controller supplies the number of accesses still in flight, whether any bank of the rank is open, the rank power state, and a pulse that marks the end of a self-refresh exit. The refresh period, precharge time and refresh recovery time are inputs, so they can be programmed at run time. The block drives three single-cycle command requests and a phase code. A command scheduler uses these to place the real DRAM commands on the bus.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the phase is IDLE (code 0), bursts are allowed, and wakeup, precharge-all and refresh requests are all low.
- R2: The phase output encodes IDLE=0, DRAIN=1, PD_EXIT=2, SREF_EXIT=3, PRE=4, START=5, RUN=6, and never shows 7.
- R3: The interval counter restarts at reset and in the cycle after each refresh command. The first DRAIN cycle comes tREFI+1 cycles after that restart point when the sequencer is idle.
- R4: DRAIN holds while the outstanding-access count is non-zero. It moves to PD_EXIT at the first clock edge that samples a zero count.
- R5: PD_EXIT lasts exactly one cycle. The wakeup request is high in that cycle only when the power state is not 0. Power state codes are 0 awake, 1 active power-down, 2 precharge power-down and 3 other power-down.
- R6: From PD_EXIT the sequencer enters PRE when the banks-open input is high, and START otherwise.
- R7: The precharge-all request is high in the first PRE cycle. The refresh request follows exactly tRP cycles later (tRP of at least 1).
- R8: START lasts one cycle with the refresh request high and is followed by RUN. The sequencer leaves RUN exactly tRFC cycles after the refresh cycle (tRFC of at least 2).
- R9: If the power state seen in PD_EXIT was 2, RUN ends in SREF_EXIT rather than IDLE. SREF_EXIT holds until the self-refresh-exit pulse and then enters DRAIN. That pulse has no effect in any other phase.
- R10: Bursts are allowed only in IDLE, and never in a cycle that carries a command request.
- R11: A refresh need that matures while a sequence runs is kept. After the sequence returns to IDLE, that phase lasts exactly one cycle before DRAIN.
- R12: Every command request is a single-cycle pulse, and exactly one refresh request is issued per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inflight_cnt_i | input | OUT_W | Accesses to the rank still in flight |
| banks_open_i | input | 1 | At least one bank of the rank is open |
| pwr_state_i | input | 2 | Rank power state (0 awake, 1 active power-down, 2 precharge power-down, 3 other power-down) |
| sref_exit_done_i | input | 1 | Pulse marking completion of a self-refresh exit |
| trefi_i | input | REFI_W | Refresh interval in cycles |
| trp_i | input | TIM_W | Precharge time in cycles |
| trfc_i | input | TIM_W | Refresh recovery time in cycles |
| wakeup_o | output | 1 | Request to bring the rank out of power-down |
| prea_o | output | 1 | Request for a precharge-all command |
| refresh_o | output | 1 | Request for a refresh command |
| burst_allowed_o | output | 1 | Read and write bursts may issue |
| phase_o | output | 3 | Current sequencer phase code |

## Verification
The embedded properties check a set of rules on every cycle. The phase code stays legal. DRAIN and SREF_EXIT hold while their exit condition is absent. PD_EXIT and START each last a single cycle. A matured refresh need stays latched until it is taken. The wait timer counts down in steps of one. The command requests are one-cycle pulses, and none of them overlaps the burst permission. Only the bench scenarios show the exact cycle placement of each command. Those scenarios cover the tREFI, tRP and tRFC distances, the wakeup decision for each power state, the open-bank branch, the self-refresh detour and its exit pulse, and the back-to-back refresh that a latched need causes after a long drain.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE      = 3'd0,
        PH_DRAIN     = 3'd1,
        PH_PD_EXIT   = 3'd2,
        PH_SREF_EXIT = 3'd3,
        PH_PRE       = 3'd4,
        PH_START     = 3'd5,
        PH_RUN       = 3'd6
    } rfsh_phase_e;

    typedef enum logic [1:0] {
        PWR_AWAKE    = 2'd0,
        PWR_ACT_PDN  = 2'd1,
        PWR_PRE_PDN  = 2'd2,
        PWR_OTHER_PD = 2'd3
    } rank_pwr_e;

    // Rank needs a wakeup before any command when it is not awake.
    function automatic logic pwr_needs_wake(rank_pwr_e p);
        return p != PWR_AWAKE;
    endfunction

    // Precharge power-down at refresh time sends the rank to self-refresh.
    function automatic logic pwr_goes_sref(rank_pwr_e p);
        return p == PWR_PRE_PDN;
    endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int REFI_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REFI_W-1:0] trefi_i,
    input  logic              ref_issued_i,
    input  logic              take_i,
    output logic              need_o
);
    logic [REFI_W-1:0] cnt_q;
    logic              need_q;
    logic              expire;

    // Wider compare so a tREFI of zero or all ones behaves sanely.
    assign expire = !ref_issued_i &&
                    (({1'b0, cnt_q} + (REFI_W+1)'(1)) >= {1'b0, trefi_i});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            need_q <= 1'b0;
        end else begin
            if (ref_issued_i || expire) cnt_q <= '0;
            else                        cnt_q <= cnt_q + REFI_W'(1);
            need_q <= expire || (need_q && !take_i);
        end
    end

    assign need_o = need_q;

    p_expire_sets_need_r3: assert property (@(posedge clk) disable iff (rst)
        expire |=> need_q);

    p_need_kept_r11: assert property (@(posedge clk) disable iff (rst)
        need_q && !take_i |=> need_q);

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int TIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [TIM_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [TIM_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - TIM_W'(1);
    end

    assign zero_o = (cnt_q == '0);

    p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
        !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - TIM_W'(1));

    p_zero_rests_r8: assert property (@(posedge clk) disable iff (rst)
        !load_i && zero_o |=> zero_o);

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
    import rfsh_pkg::*;
#(
    parameter int TIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             need_i,
    input  logic             drained_i,
    input  logic             banks_open_i,
    input  rank_pwr_e        pwr_i,
    input  logic             sref_done_i,
    input  logic             tmr_zero_i,
    input  logic [TIM_W-1:0] trp_i,
    input  logic [TIM_W-1:0] trfc_i,
    output logic             take_o,
    output logic             tmr_load_o,
    output logic [TIM_W-1:0] tmr_val_o,
    output rfsh_phase_e      phase_o,
    output logic             wakeup_o,
    output logic             prea_o,
    output logic             ref_o
);
    rfsh_phase_e st_q, st_n;
    logic        sref_q, sref_n;
    logic        prea_q;

    always_comb begin
        st_n       = st_q;
        sref_n     = sref_q;
        take_o     = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (st_q)
            PH_IDLE: if (need_i) begin
                st_n   = PH_DRAIN;
                take_o = 1'b1;
            end
            PH_DRAIN: if (drained_i) st_n = PH_PD_EXIT;
            PH_PD_EXIT: begin
                sref_n     = pwr_goes_sref(pwr_i);
                tmr_load_o = 1'b1;
                if (banks_open_i) begin
                    st_n      = PH_PRE;
                    tmr_val_o = trp_i - TIM_W'(1);
                end else begin
                    st_n      = PH_START;
                    tmr_val_o = trfc_i - TIM_W'(1);
                end
            end
            PH_PRE: if (tmr_zero_i) begin
                st_n       = PH_START;
                tmr_load_o = 1'b1;
                tmr_val_o  = trfc_i - TIM_W'(1);
            end
            PH_START: st_n = PH_RUN;
            PH_RUN: if (tmr_zero_i) st_n = sref_q ? PH_SREF_EXIT : PH_IDLE;
            PH_SREF_EXIT: if (sref_done_i) st_n = PH_DRAIN;
            default: st_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_IDLE;
            sref_q <= 1'b0;
            prea_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            sref_q <= sref_n;
            prea_q <= (st_n == PH_PRE) && (st_q != PH_PRE);
        end
    end

    assign phase_o  = st_q;
    assign wakeup_o = (st_q == PH_PD_EXIT) && pwr_needs_wake(pwr_i);
    assign prea_o   = prea_q;
    assign ref_o    = (st_q == PH_START);

    p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
        st_q != 3'd7);

    p_drain_hold_r4: assert property (@(posedge clk) disable iff (rst)
        st_q == PH_DRAIN && !drained_i |=> st_q == PH_DRAIN);

    p_pdexit_once_r5: assert property (@(posedge clk) disable iff (rst)
        st_q == PH_PD_EXIT |=> st_q == PH_PRE || st_q == PH_START);

    p_prea_in_pre_r7: assert property (@(posedge clk) disable iff (rst)
        prea_q |-> st_q == PH_PRE);

    p_start_to_run_r8: assert property (@(posedge clk) disable iff (rst)
        st_q == PH_START |=> st_q == PH_RUN);

    p_sref_wait_r9: assert property (@(posedge clk) disable iff (rst)
        st_q == PH_SREF_EXIT && !sref_done_i |=> st_q == PH_SREF_EXIT);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int REFI_W = 16,
    parameter int TIM_W  = 8,
    parameter int OUT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OUT_W-1:0]  inflight_cnt_i,
    input  logic              banks_open_i,
    input  logic [1:0]        pwr_state_i,
    input  logic              sref_exit_done_i,
    input  logic [REFI_W-1:0] trefi_i,
    input  logic [TIM_W-1:0]  trp_i,
    input  logic [TIM_W-1:0]  trfc_i,
    output logic              wakeup_o,
    output logic              prea_o,
    output logic              refresh_o,
    output logic              burst_allowed_o,
    output logic [2:0]        phase_o
);
    logic             need;
    logic             take;
    logic             tmr_load;
    logic [TIM_W-1:0] tmr_val;
    logic             tmr_zero;
    rfsh_phase_e      phase;
    rank_pwr_e        pwr;

    assign pwr = rank_pwr_e'(pwr_state_i);

    rfsh_interval #(.REFI_W(REFI_W)) u_interval (
        .clk          (clk),
        .rst          (rst),
        .trefi_i      (trefi_i),
        .ref_issued_i (refresh_o),
        .take_i       (take),
        .need_o       (need)
    );

    rfsh_timer #(.TIM_W(TIM_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    rfsh_fsm #(.TIM_W(TIM_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .need_i       (need),
        .drained_i    (inflight_cnt_i == '0),
        .banks_open_i (banks_open_i),
        .pwr_i        (pwr),
        .sref_done_i  (sref_exit_done_i),
        .tmr_zero_i   (tmr_zero),
        .trp_i        (trp_i),
        .trfc_i       (trfc_i),
        .take_o       (take),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .phase_o      (phase),
        .wakeup_o     (wakeup_o),
        .prea_o       (prea_o),
        .ref_o        (refresh_o)
    );

    assign phase_o         = phase;
    assign burst_allowed_o = (phase == PH_IDLE);

    p_no_burst_with_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        burst_allowed_o |-> !(refresh_o || prea_o || wakeup_o));

    p_ref_single_r12: assert property (@(posedge clk) disable iff (rst)
        refresh_o |=> !refresh_o);

    p_prea_single_r12: assert property (@(posedge clk) disable iff (rst)
        prea_o |=> !prea_o);

    p_wake_single_r12: assert property (@(posedge clk) disable iff (rst)
        wakeup_o |=> !wakeup_o);

endmodule

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  inflight = '0;
    logic        banks_open = 1'b0;
    logic [1:0]  pwr = 2'd0;
    logic        sref_done = 1'b0;
    logic [15:0] trefi = 16'd20;
    logic [7:0]  trp = 8'd2;
    logic [7:0]  trfc = 8'd4;
    logic        wakeup, prea, refresh, burst_ok;
    logic [2:0]  phase;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_seq u_dut (
        .clk              (clk),
        .rst              (rst),
        .inflight_cnt_i   (inflight),
        .banks_open_i     (banks_open),
        .pwr_state_i      (pwr),
        .sref_exit_done_i (sref_done),
        .trefi_i          (trefi),
        .trp_i            (trp),
        .trfc_i           (trfc),
        .wakeup_o         (wakeup),
        .prea_o           (prea),
        .refresh_o        (refresh),
        .burst_allowed_o  (burst_ok),
        .phase_o          (phase)
    );

    // Fields: tREFI, tRP, tRFC, banks_open, pwr, extra drain cycles,
    // expected wakeup edge, precharge edge, refresh edge, idle-return edge (0 = none)
    localparam int unsigned NROW = 5;
    localparam int unsigned TBL [NROW][10] = '{
        '{20, 3,  6, 0, 0, 0,  0,  0, 23, 29},
        '{20, 3,  6, 1, 0, 0,  0, 23, 26, 32},
        '{16, 1,  2, 1, 1, 4, 22, 23, 24, 26},
        '{30, 5, 10, 0, 1, 2, 34,  0, 35, 45},
        '{12, 2,  3, 1, 3, 1, 15, 16, 18, 21}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        edge_n++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sref_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        edge_n = 0;
    endtask

    task automatic run_row(input int r);
        int t, h, we, pe, re, ie;
        int w_cnt, p_cnt, r_cnt, w_at, p_at, r_at, i_at;
        t = TBL[r][0]; h = TBL[r][5];
        we = TBL[r][6]; pe = TBL[r][7]; re = TBL[r][8]; ie = TBL[r][9];
        trefi = 16'(t); trp = 8'(TBL[r][1]); trfc = 8'(TBL[r][2]);
        banks_open = TBL[r][3][0]; pwr = 2'(TBL[r][4]);
        inflight = 6'd2;
        do_reset();
        w_cnt = 0; p_cnt = 0; r_cnt = 0; w_at = 0; p_at = 0; r_at = 0; i_at = 0;
        for (int n = 1; n <= ie + 3; n++) begin
            tick();
            if (wakeup)  begin w_cnt++; w_at = n; end
            if (prea)    begin p_cnt++; p_at = n; end
            if (refresh) begin r_cnt++; r_at = n; end
            if (burst_ok && n > t + 1 && i_at == 0) i_at = n;
            if (n == t + 1) begin
                check(phase == 3'd1, "R2 drain code", phase, 1);
                check(!burst_ok, "R10 burst blocked", burst_ok, 0);
            end
            if (n == t + 2 + h) check(phase == 3'd2, "R4 pd_exit after drain", phase, 2);
            if (pe != 0 && n == pe) check(phase == 3'd4, "R6 pre code", phase, 4);
            if (n == re + 1) check(phase == 3'd6, "R8 run code", phase, 6);
            if (n >= t + 1 + h) inflight = 6'd0;
        end
        check(w_cnt == (we != 0 ? 1 : 0) && w_at == we, "R5 wakeup edge", w_at, we);
        check(p_cnt == (pe != 0 ? 1 : 0) && p_at == pe, "R7 precharge edge", p_at, pe);
        check(r_cnt == 1, "R12 one refresh", r_cnt, 1);
        check(r_at == re, "R7 refresh edge", r_at, re);
        check(i_at == ie, "R8 idle return", i_at, ie);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w_cnt, r_cnt;
        // R1: reset state
        do_reset();
        check(phase == 3'd0, "R1 phase", phase, 0);
        check(burst_ok, "R1 burst", burst_ok, 1);
        check(!refresh && !prea && !wakeup, "R1 commands", {refresh, prea, wakeup}, 0);
        tick();
        check(phase == 3'd0 && burst_ok, "R1 first cycle idle", phase, 0);

        for (int r = 0; r < NROW; r++) run_row(r);

        // R3: interval restarts after refresh command
        trefi = 16'd20; trp = 8'd2; trfc = 8'd4; banks_open = 1'b0; pwr = 2'd0;
        inflight = '0;
        do_reset();
        while (edge_n < 44) tick();
        check(phase == 3'd0 && burst_ok, "R3 still idle", phase, 0);
        tick();
        check(phase == 3'd1, "R3 drain at interval", phase, 1);

        // R9: self-refresh detour; stray exit pulse in IDLE ignored
        trefi = 16'd40; pwr = 2'd2;
        do_reset();
        w_cnt = 0; r_cnt = 0;
        while (edge_n < 4) tick();
        sref_done = 1'b1;
        tick();
        sref_done = 1'b0;
        check(phase == 3'd0 && burst_ok, "R9 pulse ignored in idle", phase, 0);
        while (edge_n < 62) begin
            tick();
            if (wakeup) w_cnt++;
            if (refresh) r_cnt++;
            if (edge_n == 47) pwr = 2'd0;
            if (edge_n == 50) begin
                check(phase == 3'd3, "R9 parked in sref_exit", phase, 3);
                check(!burst_ok, "R10 no burst in sref_exit", burst_ok, 0);
            end
            if (edge_n == 52) sref_done = 1'b1;
            if (edge_n == 53) begin
                sref_done = 1'b0;
                check(phase == 3'd1, "R9 drain after exit", phase, 1);
            end
            if (edge_n == 55) check(refresh, "R9 second refresh", refresh, 1);
            if (edge_n == 59) check(burst_ok, "R8 idle after second run", burst_ok, 1);
        end
        check(w_cnt == 1, "R5 single wakeup", w_cnt, 1);
        check(r_cnt == 2, "R12 refresh count", r_cnt, 2);

        // R11: need maturing during a long drain is kept
        trefi = 16'd10; trp = 8'd1; trfc = 8'd2; pwr = 2'd0; banks_open = 1'b0;
        inflight = 6'd5;
        do_reset();
        while (edge_n < 29) begin
            tick();
            if (edge_n == 26) inflight = 6'd0;
            if (edge_n == 20) check(phase == 3'd1, "R4 drain holds", phase, 1);
        end
        check(!burst_ok, "R10 blocked in run", burst_ok, 0);
        tick();
        check(burst_ok && phase == 3'd0, "R11 one idle cycle", phase, 0);
        tick();
        check(phase == 3'd1 && !burst_ok, "R11 back to drain", phase, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule